// File: doc/BRIEF.md
# Indexed Port Register Bank

This block is the host-visible control window of a display adapter. The host sees a few I/O ports: an index port, a value port and an interrupt status port. It writes a register number to the index port. It then reads or writes that register through the value port. The bank holds an identity word, mode registers (enable, width, height), read-only limits, a capability word, a synchronisation pair and an interrupt mask. It also maps a colour-map window and a small set of scratch words into the same index space.

A write to the synchronisation register wakes the command engine with a one-cycle kick. It also marks the engine busy and records the written value as a reason code. The busy flag stays set until the command engine reports, through a drain-complete input, that its queue is empty. Three event inputs from the engine (fence passed, queue progress, fence goal reached) latch into pending flags. Those flags, gated by the mask, drive a level interrupt line. The host clears the flags by writing ones to the status port.

Top module: `idx_reg_port`

## Requirements
- R1: After reset the index is 0, `io_rdata` is 0, and `irq`, `busy` and `sync_kick` are low.
- R2: Register 0 reads as the identity word 0x90000000 OR `VERSION`, which is 0x90000002 by default. It can be reached from a fresh index.
- R3: Port offset 0 (index port) stores the register number and reads it back. Port offset 1 (value port) reads and writes the register that the stored index selects. Register 1 (enable, bit 0), register 2 (width, 32 bits) and register 3 (height, 32 bits) read back what was written.
- R4: Read-only registers ignore writes. These are register 0 (identity), register 4 (max width, 2360), register 5 (max height, 1770), register 17 (capabilities, `CAPS`) and register 29 (scratch count).
- R5: A value-port write to register 21 (sync) sets `busy` from the next cycle and pulses `sync_kick` high for exactly one cycle. The written value is kept as a reason code that register 21 reads back. Register 22 reads `busy` in bit 0.
- R6: A cycle with `drain_done` high clears `busy`. If a sync write and `drain_done` fall in the same cycle, `busy` stays set.
- R7: Registers 1024 to 1791 form a 768-entry colour map. Each entry stores the low 8 bits of a write and reads back zero-extended.
- R8: Registers 1792 to 1792+`SCRATCH_N`-1 are 32-bit read/write scratch words.
- R9: Any other index reads 0, and a write to it changes no register. This covers 6 to 16, 18 to 20, 23 to 28, 30 to 32, 34 to 1023, and any index beyond the scratch words.
- R10: Event inputs latch into pending flags: bit 0 for fence passed, bit 1 for progress, bit 2 for fence goal. A read of port offset 8 (status) returns the pending flags ANDed with the mask. Register 33 holds the 3-bit mask.
- R11: Writing ones to the status port clears the matching pending bits. An event in the same cycle as its clear leaves the bit set.
- R12: `irq` is high exactly when some pending flag is enabled in the mask. It rises in the cycle after the edge that latched the event.
- R13: When bit 18 (0x00040000) of `CAPS` is clear, the mask reads 0 and `irq` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port offset: 0 index, 1 value, 8 interrupt status |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, registered on a read strobe |
| ev_fence | input | 1 | Fence passed event |
| ev_progress | input | 1 | Command queue progress event |
| ev_goal | input | 1 | Fence goal reached event |
| drain_done | input | 1 | Command queue fully drained |
| sync_kick | output | 1 | One-cycle wake-up to the command engine |
| busy | output | 1 | Command engine marked busy |
| irq | output | 1 | Interrupt request |

## Verification
Every result appears one clock after its stimulus:
- Read data is registered on the edge that samples `io_rd`.
- A write changes state on the edge that samples `io_wr`.
- `busy`, `sync_kick` and the pending flags change on the edge that sees the sync write, `drain_done` or the event.
- `irq` is decoded from flops, so it follows them on that same edge.

The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It reads results on the next falling edge, which is the first point where the new value is settled. The one-cycle width of `sync_kick` is checked on that falling edge and again one falling edge later.

// File: rtl/irp_pkg.sv
package irp_pkg;

    localparam int IDX_W = 16;

    localparam logic [3:0] PORT_INDEX = 4'h0;
    localparam logic [3:0] PORT_VALUE = 4'h1;
    localparam logic [3:0] PORT_IRQ   = 4'h8;

    localparam logic [31:0] ID_MAGIC = 32'h9000_0000;

    localparam logic [IDX_W-1:0] RI_ID      = 16'd0;
    localparam logic [IDX_W-1:0] RI_ENABLE  = 16'd1;
    localparam logic [IDX_W-1:0] RI_WIDTH   = 16'd2;
    localparam logic [IDX_W-1:0] RI_HEIGHT  = 16'd3;
    localparam logic [IDX_W-1:0] RI_MAXW    = 16'd4;
    localparam logic [IDX_W-1:0] RI_MAXH    = 16'd5;
    localparam logic [IDX_W-1:0] RI_CAPS    = 16'd17;
    localparam logic [IDX_W-1:0] RI_SYNC    = 16'd21;
    localparam logic [IDX_W-1:0] RI_BUSY    = 16'd22;
    localparam logic [IDX_W-1:0] RI_SCRNUM  = 16'd29;
    localparam logic [IDX_W-1:0] RI_IRQMASK = 16'd33;

    localparam int PAL_LEN = 768;
    localparam logic [IDX_W-1:0] PAL_BASE = 16'd1024;
    localparam logic [IDX_W-1:0] PAL_END  = 16'd1792;
    localparam logic [IDX_W-1:0] SCR_BASE = 16'd1792;

    localparam int IRQ_BITS = 3;
    localparam int CAP_IRQ_BIT = 18;

endpackage

// File: rtl/irp_palette.sv
module irp_palette #(
    parameter int ENTRIES = 768,
    parameter int DW      = 8,
    localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    // Storage array: written in place, no reset, so it maps to a RAM.
    logic [DW-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/irp_sync_track.sv
module irp_sync_track (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sync_wr,
    input  logic [31:0] sync_data,
    input  logic        drain_done,
    output logic        busy,
    output logic        kick,
    output logic [31:0] reason
);
    typedef struct packed {
        logic        busy;
        logic        kick;
        logic [31:0] reason;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kick = sync_wr;
        if (sync_wr) begin
            st_d.busy   = 1'b1;   // a fresh request outranks a drain report
            st_d.reason = sync_data;
        end else if (drain_done) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign kick   = st_q.kick;
    assign reason = st_q.reason;
endmodule

// File: rtl/irp_irq_unit.sv
module irp_irq_unit #(
    parameter int  NB     = 3,
    parameter bit  IRQ_OK = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] events,
    input  logic          mask_wr,
    input  logic [NB-1:0] mask_data,
    input  logic          clr_wr,
    input  logic [NB-1:0] clr_data,
    output logic [NB-1:0] mask,
    output logic [NB-1:0] status,
    output logic          irq
);
    typedef struct packed {
        logic [NB-1:0] pending;
        logic [NB-1:0] mask;
    } irq_state_t;

    irq_state_t    st_d, st_q;
    logic [NB-1:0] clr_bits;
    logic [NB-1:0] mask_next;

    generate
        if (IRQ_OK) begin : g_mask_live
            assign mask_next = mask_wr ? mask_data : st_q.mask;
        end else begin : g_mask_dead
            assign mask_next = '0;
        end
    endgenerate

    always_comb begin
        clr_bits     = clr_wr ? clr_data : '0;
        st_d.pending = (st_q.pending & ~clr_bits) | events;
        st_d.mask    = mask_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask   = st_q.mask;
    assign status = st_q.pending & st_q.mask;
    assign irq    = |status;
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
    import irp_pkg::*;
#(
    parameter logic [7:0]  VERSION   = 8'd2,
    parameter logic [31:0] CAPS      = 32'h0004_0023,
    parameter int          SCRATCH_N = 8,
    parameter logic [31:0] MAX_W     = 32'd2360,
    parameter logic [31:0] MAX_H     = 32'd1770
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    input  logic        ev_fence,
    input  logic        ev_progress,
    input  logic        ev_goal,
    input  logic        drain_done,
    output logic        sync_kick,
    output logic        busy,
    output logic        irq
);
    localparam int           PAL_AW  = $clog2(PAL_LEN);
    localparam int           SCR_AW  = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;
    localparam logic [IDX_W-1:0] SCR_END = SCR_BASE + IDX_W'(SCRATCH_N);
    localparam bit           IRQ_OK  = CAPS[CAP_IRQ_BIT];
    localparam logic [31:0]  ID_WORD = ID_MAGIC | {24'd0, VERSION};

    typedef struct packed {
        logic [IDX_W-1:0]              index;
        logic                          enable;
        logic [31:0]                   width;
        logic [31:0]                   height;
        logic [31:0]                   rdata;
        logic [SCRATCH_N-1:0][31:0]    scratch;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                value_wr;
    logic                sync_wr;
    logic                mask_wr;
    logic                clr_wr;
    logic                in_pal;
    logic                in_scr;
    logic [PAL_AW-1:0]   pal_addr;
    logic [SCR_AW-1:0]   scr_addr;
    logic [7:0]          pal_rd;
    logic [31:0]         sync_reason;
    logic [IRQ_BITS-1:0] irq_mask;
    logic [IRQ_BITS-1:0] irq_status;
    logic [31:0]         reg_val;
    logic [31:0]         port_val;
    logic                caps_irq;

    assign caps_irq = IRQ_OK;

    // Address decode of the current index
    always_comb begin
        value_wr = io_wr && (io_addr == PORT_VALUE);
        sync_wr  = value_wr && (st_q.index == RI_SYNC);
        mask_wr  = value_wr && (st_q.index == RI_IRQMASK);
        clr_wr   = io_wr && (io_addr == PORT_IRQ);
        in_pal   = (st_q.index >= PAL_BASE) && (st_q.index < PAL_END);
        in_scr   = (st_q.index >= SCR_BASE) && (st_q.index < SCR_END);
        pal_addr = PAL_AW'(st_q.index - PAL_BASE);
        scr_addr = SCR_AW'(st_q.index - SCR_BASE);
    end

    irp_palette #(
        .ENTRIES (PAL_LEN),
        .DW      (8)
    ) i_palette (
        .clk     (clk),
        .wr_en   (value_wr && in_pal),
        .wr_addr (pal_addr),
        .wr_data (io_wdata[7:0]),
        .rd_addr (pal_addr),
        .rd_data (pal_rd)
    );

    irp_sync_track i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_wr    (sync_wr),
        .sync_data  (io_wdata),
        .drain_done (drain_done),
        .busy       (busy),
        .kick       (sync_kick),
        .reason     (sync_reason)
    );

    irp_irq_unit #(
        .NB     (IRQ_BITS),
        .IRQ_OK (IRQ_OK)
    ) i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .events    ({ev_goal, ev_progress, ev_fence}),
        .mask_wr   (mask_wr),
        .mask_data (io_wdata[IRQ_BITS-1:0]),
        .clr_wr    (clr_wr),
        .clr_data  (io_wdata[IRQ_BITS-1:0]),
        .mask      (irq_mask),
        .status    (irq_status),
        .irq       (irq)
    );

    // Value-port read mux
    always_comb begin
        reg_val = '0;
        if (in_pal) begin
            reg_val = {24'd0, pal_rd};
        end else if (in_scr) begin
            reg_val = st_q.scratch[scr_addr];
        end else begin
            unique case (st_q.index)
                RI_ID:      reg_val = ID_WORD;
                RI_ENABLE:  reg_val = {31'd0, st_q.enable};
                RI_WIDTH:   reg_val = st_q.width;
                RI_HEIGHT:  reg_val = st_q.height;
                RI_MAXW:    reg_val = MAX_W;
                RI_MAXH:    reg_val = MAX_H;
                RI_CAPS:    reg_val = CAPS;
                RI_SYNC:    reg_val = sync_reason;
                RI_BUSY:    reg_val = {31'd0, busy};
                RI_SCRNUM:  reg_val = 32'(SCRATCH_N);
                RI_IRQMASK: reg_val = {{(32-IRQ_BITS){1'b0}}, irq_mask};
                default:    reg_val = '0;
            endcase
        end
    end

    always_comb begin
        unique case (io_addr)
            PORT_INDEX: port_val = {{(32-IDX_W){1'b0}}, st_q.index};
            PORT_VALUE: port_val = reg_val;
            PORT_IRQ:   port_val = {{(32-IRQ_BITS){1'b0}}, irq_status};
            default:    port_val = '0;
        endcase
    end

    // Next-state for index, mode registers, scratch and read data
    always_comb begin
        st_d = st_q;
        if (io_rd) begin
            st_d.rdata = port_val;
        end
        if (io_wr && (io_addr == PORT_INDEX)) begin
            st_d.index = io_wdata[IDX_W-1:0];
        end
        if (value_wr) begin
            if (in_scr) begin
                st_d.scratch[scr_addr] = io_wdata;
            end else if (!in_pal) begin
                unique case (st_q.index)
                    RI_ENABLE: st_d.enable = io_wdata[0];
                    RI_WIDTH:  st_d.width  = io_wdata;
                    RI_HEIGHT: st_d.height = io_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata = st_q.rdata;
endmodule

// File: rtl/irp_checker.sv
module irp_checker (
    input logic clk,
    input logic rst_n,
    input logic sync_wr,
    input logic mask_wr,
    input logic drain_done,
    input logic busy,
    input logic sync_kick,
    input logic ev_any,
    input logic caps_irq,
    input logic irq
);
    // R5: a sync write marks the engine busy on the next cycle
    assert_busy_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_wr |=> busy);

    // R5: the wake-up pulse only follows a sync write
    assert_kick_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_kick |-> $past(sync_wr));

    // R6: drain report without a new sync clears busy
    assert_busy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && drain_done && !sync_wr) |=> !busy);

    // R12: the interrupt only rises after an event or a mask change
    assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_any || mask_wr));

    // R13: no interrupt without the capability
    assert_irq_gated_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !caps_irq |-> !irq);
endmodule

bind idx_reg_port irp_checker i_irp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_wr    (sync_wr),
    .mask_wr    (mask_wr),
    .drain_done (drain_done),
    .busy       (busy),
    .sync_kick  (sync_kick),
    .ev_any     (ev_fence || ev_progress || ev_goal),
    .caps_irq   (caps_irq),
    .irq        (irq)
);

// File: tb/test_idx_reg_port.sv
module test_idx_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [31:0] io_rdata_n;
    logic        ev_fence = 1'b0;
    logic        ev_progress = 1'b0;
    logic        ev_goal = 1'b0;
    logic        drain_done = 1'b0;
    logic        sync_kick, busy, irq;
    logic        sync_kick_n, busy_n, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    idx_reg_port i_idx_reg_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ev_fence(ev_fence),
        .ev_progress(ev_progress), .ev_goal(ev_goal), .drain_done(drain_done),
        .sync_kick(sync_kick), .busy(busy), .irq(irq)
    );

    // Variant without the interrupt capability
    idx_reg_port #(.CAPS(32'h0000_0023)) i_idx_reg_port_noirq (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata_n), .ev_fence(ev_fence),
        .ev_progress(ev_progress), .ev_goal(ev_goal), .drain_done(drain_done),
        .sync_kick(sync_kick_n), .busy(busy_n), .irq(irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic port_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic port_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic reg_write(input int idx, input logic [31:0] d);
        port_write(4'h0, 32'(idx));
        port_write(4'h1, d);
    endtask

    task automatic reg_read(input int idx, output logic [31:0] d);
        port_write(4'h0, 32'(idx));
        port_read(4'h1, d);
    endtask

    task automatic pulse_events(input logic f, input logic p, input logic g);
        @(negedge clk);
        ev_fence = f; ev_progress = p; ev_goal = g;
        @(negedge clk);
        ev_fence = 1'b0; ev_progress = 1'b0; ev_goal = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 kick", {31'd0, sync_kick}, 32'd0);
        check("R1 rdata", io_rdata, 32'd0);
        port_read(4'h0, v);
        check("R1 index", v, 32'd0);
    endtask

    task automatic t_identity;
        logic [31:0] v;
        port_read(4'h1, v);
        check("R2 id at reset index", v, 32'h9000_0002);
        reg_read(0, v);
        check("R2 id", v, 32'h9000_0002);
    endtask

    task automatic t_mode_regs;
        logic [31:0] v;
        reg_write(2, 32'h1234_5678);
        reg_write(3, 32'h0000_0300);
        reg_write(1, 32'hFFFF_FFFF);
        reg_read(2, v);
        check("R3 width", v, 32'h1234_5678);
        reg_read(3, v);
        check("R3 height", v, 32'h0000_0300);
        port_read(4'h0, v);
        check("R3 index readback", v, 32'd3);
        reg_read(1, v);
        check("R3 enable", v, 32'd1);
    endtask

    task automatic t_read_only;
        logic [31:0] v;
        reg_write(0, 32'hDEAD_BEEF);
        reg_read(0, v);
        check("R4 id write ignored", v, 32'h9000_0002);
        reg_write(17, 32'h0);
        reg_read(17, v);
        check("R4 caps", v, 32'h0004_0023);
        reg_write(4, 32'h1);
        reg_read(4, v);
        check("R4 max width", v, 32'd2360);
        reg_read(5, v);
        check("R4 max height", v, 32'd1770);
        reg_read(29, v);
        check("R4 scratch count", v, 32'd8);
    endtask

    task automatic t_sync;
        logic [31:0] v;
        port_write(4'h0, 32'd21);
        @(negedge clk);
        io_addr = 4'h1; io_wdata = 32'h0000_0ABC; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R5 kick high", {31'd0, sync_kick}, 32'd1);
        check("R5 busy set", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check("R5 kick one cycle", {31'd0, sync_kick}, 32'd0);
        port_read(4'h1, v);
        check("R5 reason", v, 32'h0000_0ABC);
        reg_read(22, v);
        check("R5 busy reg", v, 32'd1);
    endtask

    task automatic t_drain;
        logic [31:0] v;
        @(negedge clk);
        drain_done = 1'b1;
        @(negedge clk);
        drain_done = 1'b0;
        check("R6 busy cleared", {31'd0, busy}, 32'd0);
        reg_read(22, v);
        check("R6 busy reg cleared", v, 32'd0);
        port_write(4'h0, 32'd21);
        @(negedge clk);
        io_addr = 4'h1; io_wdata = 32'h77; io_wr = 1'b1; drain_done = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; drain_done = 1'b0;
        check("R6 sync beats drain", {31'd0, busy}, 32'd1);
        @(negedge clk);
        drain_done = 1'b1;
        @(negedge clk);
        drain_done = 1'b0;
        check("R6 busy cleared again", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_palette;
        logic [31:0] v;
        reg_write(1024, 32'h0000_01FF);
        reg_write(1791, 32'h0000_005A);
        reg_read(1024, v);
        check("R7 palette first", v, 32'h0000_00FF);
        reg_read(1791, v);
        check("R7 palette last", v, 32'h0000_005A);
    endtask

    task automatic t_scratch;
        logic [31:0] v;
        reg_write(1792, 32'hCAFE_F00D);
        reg_write(1799, 32'h0BAD_C0DE);
        reg_read(1792, v);
        check("R8 scratch first", v, 32'hCAFE_F00D);
        reg_read(1799, v);
        check("R8 scratch last", v, 32'h0BAD_C0DE);
    endtask

    task automatic t_out_of_range;
        logic [31:0] v;
        reg_write(41, 32'hFFFF_FFFF);
        reg_read(41, v);
        check("R9 index 41", v, 32'd0);
        reg_write(1023, 32'h55);
        reg_read(1023, v);
        check("R9 index 1023", v, 32'd0);
        reg_write(1800, 32'h1234);
        reg_read(1800, v);
        check("R9 past scratch", v, 32'd0);
        reg_read(2, v);
        check("R9 width untouched", v, 32'h1234_5678);
        reg_read(1792, v);
        check("R9 scratch untouched", v, 32'hCAFE_F00D);
        reg_read(1024, v);
        check("R9 palette untouched", v, 32'h0000_00FF);
    endtask

    task automatic t_flags;
        logic [31:0] v;
        reg_write(33, 32'hFFFF_FFFF);
        reg_read(33, v);
        check("R10 mask", v, 32'd7);
        pulse_events(1'b0, 1'b1, 1'b0);
        port_read(4'h8, v);
        check("R10 progress flag", v, 32'd2);
        reg_write(33, 32'd1);
        port_read(4'h8, v);
        check("R10 masked status", v, 32'd0);
        check("R12 irq masked off", {31'd0, irq}, 32'd0);
        reg_write(33, 32'd7);
        port_read(4'h8, v);
        check("R10 pending kept", v, 32'd2);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        port_write(4'h8, 32'd2);
        port_read(4'h8, v);
        check("R11 clear", v, 32'd0);
        pulse_events(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        io_addr = 4'h8; io_wdata = 32'd1; io_wr = 1'b1; ev_fence = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; ev_fence = 1'b0;
        port_read(4'h8, v);
        check("R11 event beats clear", v, 32'd1);
        port_write(4'h8, 32'd7);
        port_read(4'h8, v);
        check("R11 clear all", v, 32'd0);
    endtask

    task automatic t_irq;
        reg_write(33, 32'd4);
        check("R12 irq idle", {31'd0, irq}, 32'd0);
        @(negedge clk);
        ev_goal = 1'b1;
        @(negedge clk);
        ev_goal = 1'b0;
        check("R12 irq raised", {31'd0, irq}, 32'd1);
        port_write(4'h8, 32'd4);
        check("R12 irq dropped", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_no_cap;
        logic [31:0] v;
        reg_write(33, 32'd7);
        port_write(4'h0, 32'd33);
        @(negedge clk);
        io_addr = 4'h1; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check("R13 mask zero", io_rdata_n, 32'd0);
        check("R13 mask live on capable", io_rdata, 32'd7);
        pulse_events(1'b1, 1'b1, 1'b1);
        check("R13 irq held low", {31'd0, irq_n}, 32'd0);
        check("R13 capable irq", {31'd0, irq}, 32'd1);
        port_read(4'h8, v);
        check("R13 status on capable", v, 32'd7);
        port_write(4'h8, 32'd7);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_identity();
        t_mode_regs();
        t_read_only();
        t_sync();
        t_drain();
        t_palette();
        t_scratch();
        t_out_of_range();
        t_flags();
        t_clear();
        t_irq();
        t_no_cap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule